// File: doc/BRIEF.md
# LIN-capable UART transmitter

This block is an asynchronous serial transmitter for 8-bit data with a one-entry holding buffer. It adds a Break mode, which is needed to open a LIN frame header. The host enables the transmitter and writes bytes through a strobe. Each byte waits in the holding buffer until the shift register can take it. A baud tick supplied from outside the block sets the length of each bit: one bit lasts one tick period.

To send a Break, the host raises the send-break request while the transmitter is enabled. The next data write then launches a long all-zero character, and the written value is thrown away. While the Break is on the line, the host may load the next byte, usually the Sync value 0x55. That byte follows straight after the Break's stop bit. The request clears itself once the Break has finished, so the next write is a normal frame again. Dropping the enable flushes everything and returns the line to idle.

Top module: `lin_uart_tx`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `shift_idle` is 1 and `brk_pending` is 0. Whenever the shifter is idle, the line is held high.
- R2: A normal frame is one low start bit, then the 8 data bits with bit 0 first, then one high stop bit. Each bit lasts exactly one baud-tick period, and a frame begins on the first baud tick after the byte reaches the holding buffer.
- R3: A Break is a low start bit, then 12 low bits, then a high stop bit. The line is therefore low for 13 tick periods. The value written to launch the Break never appears on the line.
- R4: `brk_pending` rises one cycle after a `brk_set` pulse while `tx_en` is 1. It stays high until the baud tick that ends the Break's stop bit, and falls on that tick.
- R5: A byte written while a Break is in progress is a normal frame. Its start bit begins on the tick that ends the Break's stop bit, with no idle gap.
- R6: `shift_idle` is 0 for the whole of any frame, Break or normal, from its start bit through its stop bit.
- R7: `hold_empty` falls one cycle after an accepted write and rises one cycle after the shift register takes the byte. A write while the buffer is full is ignored.
- R8: If the buffer holds a byte when a stop bit ends, the next start bit follows on that same tick. Two frames therefore take exactly 20 tick periods.
- R9: While `tx_en` is 0, the line is high, the buffer is empty, no Break is pending, and writes and `brk_set` pulses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| tx_en | input | 1 | Transmit enable; low flushes the block |
| brk_set | input | 1 | Pulse that arms a Break for the next write |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding buffer can take a byte |
| shift_idle | output | 1 | No frame is on the line |
| brk_pending | output | 1 | Break request still active |

## Verification
The corner cases are these: the Sync byte written during a Break, a write that arrives while the buffer is still full, and the enable dropping in the middle of a frame. Each one changes the line or the flags a few cycles later, so a reference model and the design are compared on every clock. Any of the following would show up as a line mismatch or as a wrong low-run length: a design that sent the discarded Break value, marked the Sync byte as a second Break, cleared the request before the stop bit, or left a gap between frames. A design that kept stale data after disable would put an extra frame on the line once the enable returned.

// File: rtl/lin_tx_pkg.sv
package lin_tx_pkg;
   typedef enum logic [1:0] {SH_IDLE, SH_START, SH_BODY, SH_STOP} sh_state_t;
   typedef enum logic [1:0] {BRK_NONE, BRK_ARMED, BRK_QUEUED} brk_state_t;
endpackage

// File: rtl/lin_tx_holdbuf.sv
module lin_tx_holdbuf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              mark_brk,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data,
   output logic              is_brk,
   output logic              wr_accept
);
   assign wr_accept = tx_en && wr_stb && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         data   <= '0;
         is_brk <= 1'b0;
      end else if (!tx_en) begin
         full   <= 1'b0;
         is_brk <= 1'b0;
      end else if (take) begin
         full <= 1'b0;
      end else if (wr_accept) begin
         full   <= 1'b1;
         data   <= mark_brk ? '0 : wr_data;
         is_brk <= mark_brk;
      end
   end

   AST_FULL_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && full && !take) |=> (full && $stable(data))); // R7
   AST_TAKE_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> full); // R7
endmodule

// File: rtl/lin_tx_brkctl.sv
module lin_tx_brkctl
   import lin_tx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic brk_set,
   input  logic wr_accept,
   input  logic brk_done,
   output logic mark_brk,
   output logic brk_pending
);
   brk_state_t st;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= BRK_NONE;
      end else if (!tx_en) begin
         st <= BRK_NONE;
      end else begin
         unique case (st)
            BRK_NONE:   if (brk_set)   st <= BRK_ARMED;
            BRK_ARMED:  if (wr_accept) st <= BRK_QUEUED;
            BRK_QUEUED: if (brk_done)  st <= BRK_NONE;
            default:                   st <= BRK_NONE;
         endcase
      end
   end

   assign mark_brk    = (st == BRK_ARMED);
   assign brk_pending = (st != BRK_NONE);

   AST_BRK_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(brk_pending) |-> $past(!tx_en || brk_done)); // R4
   AST_BRK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pending && tx_en && !brk_done) |=> brk_pending); // R4
endmodule

// File: rtl/lin_tx_shifter.sv
module lin_tx_shifter
   import lin_tx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int BRK_LEN   = 12,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              baud_tick,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic              hold_brk,
   output logic              take,
   output logic              line_bit,
   output logic              busy,
   output logic              brk_done
);
   localparam int BODY_MAX = (BRK_LEN > DATA_W) ? BRK_LEN : DATA_W;
   localparam int CNT_W    = (BODY_MAX > 1) ? $clog2(BODY_MAX) : 1;
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] BRK_LAST  = CNT_W'(BRK_LEN - 1);

   sh_state_t         st;
   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] shreg_nx;
   logic [CNT_W-1:0]  cnt;
   logic              cur_brk;
   logic              out_bit;
   logic              body_last;
   logic              can_load;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign out_bit  = shreg[0];
         assign shreg_nx = shreg >> 1;
      end else begin : g_msb
         assign out_bit  = shreg[DATA_W-1];
         assign shreg_nx = shreg << 1;
      end
   endgenerate

   assign body_last = (cnt == (cur_brk ? BRK_LAST : DATA_LAST));
   assign can_load  = (st == SH_IDLE) || (st == SH_STOP);
   assign take      = tx_en && baud_tick && hold_full && can_load;
   assign brk_done  = tx_en && baud_tick && (st == SH_STOP) && cur_brk;
   assign busy      = (st != SH_IDLE);

   always_comb begin
      unique case (st)
         SH_START: line_bit = 1'b0;
         SH_BODY:  line_bit = out_bit;
         default:  line_bit = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= SH_IDLE;
         shreg   <= '0;
         cnt     <= '0;
         cur_brk <= 1'b0;
      end else if (!tx_en) begin
         st      <= SH_IDLE;
         cur_brk <= 1'b0;
      end else if (baud_tick) begin
         unique case (st)
            SH_START: begin
               st  <= SH_BODY;
               cnt <= '0;
            end
            SH_BODY: begin
               if (body_last) begin
                  st <= SH_STOP;
               end else begin
                  shreg <= shreg_nx;
                  cnt   <= cnt + 1'b1;
               end
            end
            default: begin
               if (hold_full) begin
                  st      <= SH_START;
                  shreg   <= hold_brk ? '0 : hold_data;
                  cur_brk <= hold_brk;
               end else begin
                  st      <= SH_IDLE;
                  cur_brk <= 1'b0;
               end
            end
         endcase
      end
   end

   AST_START_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == SH_IDLE && st != SH_IDLE) |-> $past(hold_full && baud_tick)); // R6
   AST_BREAK_BODY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SH_BODY && cur_brk) |-> !line_bit); // R3
   AST_BIT_HOLDS_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !baud_tick) |=> ($stable(st) && $stable(cnt))); // R2
endmodule

// File: rtl/lin_uart_tx.sv
module lin_uart_tx #(
   parameter int DATA_W    = 8,
   parameter int BRK_LEN   = 12,
   parameter bit LSB_FIRST = 1'b1,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic              brk_set,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              baud_tick,
   output logic              txd,
   output logic              hold_empty,
   output logic              shift_idle,
   output logic              brk_pending
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
      if (BRK_LEN < 1) begin : g_bad_brk
         $error("BRK_LEN must be at least 1");
      end
   endgenerate

   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              hold_brk;
   logic              wr_accept;
   logic              mark_brk;
   logic              take;
   logic              line_bit;
   logic              busy;
   logic              brk_done;

   lin_tx_holdbuf #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_stb(wr_stb),
      .wr_data(wr_data), .mark_brk(mark_brk), .take(take),
      .full(hold_full), .data(hold_data), .is_brk(hold_brk),
      .wr_accept(wr_accept)
   );

   lin_tx_brkctl u_brk (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_set(brk_set),
      .wr_accept(wr_accept), .brk_done(brk_done),
      .mark_brk(mark_brk), .brk_pending(brk_pending)
   );

   lin_tx_shifter #(.DATA_W(DATA_W), .BRK_LEN(BRK_LEN), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
      .hold_full(hold_full), .hold_data(hold_data), .hold_brk(hold_brk),
      .take(take), .line_bit(line_bit), .busy(busy), .brk_done(brk_done)
   );

   generate
      if (REG_OUT) begin : g_reg_out
         logic txd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) txd_q <= 1'b1;
            else        txd_q <= line_bit;
         end
         assign txd = txd_q;
      end else begin : g_comb_out
         assign txd = line_bit;
      end
   endgenerate

   assign hold_empty = !hold_full;
   assign shift_idle = !busy;

   AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_idle && $past(shift_idle)) |-> txd); // R1
   AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en |=> (hold_empty && shift_idle && !brk_pending)); // R9
endmodule

// File: tb/sim_lin_uart_tx.sv
module sim_lin_uart_tx;
   localparam int CLK_PER = 10;
   localparam int TDIV    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic       brk_set = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       baud_tick = 1'b0;
   logic       txd, hold_empty, shift_idle, brk_pending;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int low_run = 0;
   int max_low = 0;
   int last_fall = 0;
   int last_rise = 0;
   bit prev_idle = 1'b1;
   bit finished = 1'b0;
   string phase = "R1";

   lin_uart_tx u0 (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_set(brk_set),
      .wr_stb(wr_stb), .wr_data(wr_data), .baud_tick(baud_tick),
      .txd(txd), .hold_empty(hold_empty), .shift_idle(shift_idle),
      .brk_pending(brk_pending)
   );

   always #(CLK_PER/2) clk = ~clk;

   int tcnt = 0;
   always @(negedge clk) begin
      tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      baud_tick <= (tcnt == TDIV - 1);
   end

   // behavioural reference model
   bit         m_busy;
   bit         m_cur;
   bit         m_curbrk;
   int         m_brk;
   bit         m_bits[$];
   logic [7:0] m_hd[$];
   bit         m_hb[$];
   bit         pre_empty;
   int         pre_brk;
   bit         stopdone;
   bit         wacc;

   task automatic m_load();
      logic [7:0] d;
      bit b;
      d = m_hd.pop_front();
      b = m_hb.pop_front();
      m_bits.delete();
      m_cur = 1'b0;
      if (b) begin
         for (int i = 0; i < 12; i++) m_bits.push_back(1'b0);
      end else begin
         for (int i = 0; i < 8; i++) m_bits.push_back(d[i]);
      end
      m_bits.push_back(1'b1);
      m_busy = 1'b1;
      m_curbrk = b;
   endtask

   always @(posedge clk) begin
      if (!rst_n || !tx_en) begin
         m_busy = 1'b0; m_cur = 1'b1; m_curbrk = 1'b0; m_brk = 0;
         m_bits.delete(); m_hd.delete(); m_hb.delete();
      end else begin
         pre_empty = (m_hd.size() == 0);
         pre_brk   = m_brk;
         stopdone  = 1'b0;
         wacc      = wr_stb && pre_empty;
         if (baud_tick) begin
            if (m_busy) begin
               if (m_bits.size() > 0) m_cur = m_bits.pop_front();
               else begin
                  stopdone = m_curbrk;
                  m_busy = 1'b0;
                  m_curbrk = 1'b0;
               end
            end
            if (!m_busy && !pre_empty) m_load();
         end
         if (wacc) begin
            m_hd.push_back(wr_data);
            m_hb.push_back(pre_brk == 1);
         end
         if (pre_brk == 2 && stopdone) m_brk = 0;
         else if (pre_brk == 0 && brk_set) m_brk = 1;
         else if (pre_brk == 1 && wacc) m_brk = 2;
      end
   end

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
      end
   endtask

   task automatic chk_int(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison, away from the active edge
   always @(posedge clk) begin
      #(CLK_PER/4);
      cyc++;
      if (rst_n && !finished) begin
         chk(phase, "txd", txd, m_busy ? m_cur : 1'b1);      // R2/R3 line
         chk("R7", "hold_empty", hold_empty, m_hd.size() == 0);
         chk("R6", "shift_idle", shift_idle, !m_busy);
         chk("R4", "brk_pending", brk_pending, m_brk != 0);
         if (!txd) low_run++; else low_run = 0;
         if (low_run > max_low) max_low = low_run;
         if (prev_idle && !shift_idle) last_fall = cyc;
         if (!prev_idle && shift_idle) last_rise = cyc;
         prev_idle = shift_idle;
      end
      if (cyc > 100000 && !finished) begin
         finished = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic write_byte(logic [7:0] d);
      @(negedge clk); wr_stb = 1'b1; wr_data = d;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic pulse_brk();
      @(negedge clk); brk_set = 1'b1;
      @(negedge clk); brk_set = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (shift_idle && hold_empty) break;
      end
   endtask

   task automatic wait_hold_empty();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (hold_empty) break;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "reset txd", txd, 1'b1);
      chk("R1", "reset hold_empty", hold_empty, 1'b1);
      chk("R1", "reset shift_idle", shift_idle, 1'b1);
      chk("R1", "reset brk_pending", brk_pending, 1'b0);
      tx_en = 1'b1;

      // R2: normal frames, several patterns
      phase = "R2";
      write_byte(8'hA5); wait_idle();
      write_byte(8'h80); wait_idle();
      max_low = 0;
      write_byte(8'h00); wait_idle();
      chk_int("R2", "low run of 0x00 frame (cycles)", max_low, 9 * TDIV);
      chk_int("R2", "one frame length (cycles)", last_rise - last_fall, 10 * TDIV);

      // R7 / R8: ignored write while full, back-to-back frames
      phase = "R8";
      write_byte(8'h3C);
      chk("R7", "hold_empty after write", hold_empty, 1'b0);
      write_byte(8'h99);   // R7: buffer full, must be ignored
      wait_hold_empty();
      write_byte(8'hC3);
      wait_idle();
      chk_int("R8", "two frames length (cycles)", last_rise - last_fall, 20 * TDIV);

      // R3 / R4 / R5: break followed by sync
      phase = "R3";
      max_low = 0;
      pulse_brk();
      chk("R4", "brk_pending after set", brk_pending, 1'b1);
      write_byte(8'hFF);   // R3: value discarded
      chk("R4", "brk_pending during break", brk_pending, 1'b1);
      wait_hold_empty();
      phase = "R5";
      write_byte(8'h55);
      wait_idle();
      chk("R4", "brk_pending after break", brk_pending, 1'b0);
      chk_int("R3", "break low run (cycles)", max_low, 13 * TDIV);
      chk_int("R5", "break plus sync length (cycles)", last_rise - last_fall, 24 * TDIV);

      // R9: disable mid frame flushes everything
      phase = "R9";
      write_byte(8'h0F);
      repeat (10) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R9", "txd when disabled", txd, 1'b1);
      chk("R9", "hold_empty when disabled", hold_empty, 1'b1);
      chk("R9", "shift_idle when disabled", shift_idle, 1'b1);
      pulse_brk();
      write_byte(8'h77);
      chk("R9", "write ignored while disabled", hold_empty, 1'b1);
      chk("R9", "brk_set ignored while disabled", brk_pending, 1'b0);
      tx_en = 1'b1;
      repeat (12) @(negedge clk);
      chk("R9", "nothing sent after re-enable", shift_idle, 1'b1);

      // R9: disable clears an armed break; next write is a normal frame
      pulse_brk();
      chk("R4", "armed again", brk_pending, 1'b1);
      tx_en = 1'b0;
      @(negedge clk);
      chk("R9", "break cleared by disable", brk_pending, 1'b0);
      tx_en = 1'b1;
      max_low = 0;
      phase = "R2";
      write_byte(8'h81);
      wait_idle();
      chk_int("R9", "normal frame after cleared break, low run", max_low, 6 * TDIV);

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule